// File: doc/BRIEF.md
# Reset-Button Hold Timer

This block measures how long an active-low reset button is held down, so that boot firmware can tell a short press from a deliberate long press that asks for a factory restore. The button input is asynchronous. It is brought into the reference clock domain, and while it reads low a counter advances by one on every reference clock.

The count stops when the button is released and keeps its value until software clears it. If the button is pressed again before a clear, the new press adds to the held value. At full scale the counter stops and does not roll over. With the 29-bit default and a 25 MHz reference clock, one count is 40 ns, one second is 25,000,000 counts, and full scale is about 21.4 seconds.

A single 32-bit register port serves both directions. Reads return the count right-aligned, with zeros above it. A write with the clear bit set resets the count. The comparison against a hold-time threshold and any action taken afterwards are left to software.

Top module: `rsthold_meter`

## Requirements
- R1: After the block reset is released, `rd_data` reads zero and stays zero while the button is released and nothing is written.
- R2: The button input passes through SYNC_STAGES flops (default 2) before it controls counting. When the button goes low, the count rises by exactly one per clock, starting at the (SYNC_STAGES+1)-th rising edge after the input falls.
- R3: After the button is released, at most SYNC_STAGES further increments occur. The count then stays constant for as long as the button stays high and no clear is written.
- R4: A new press without a clear in between continues counting upward from the held value.
- R5: The count saturates at 2^CNT_W - 1 and holds that value while the button stays low. It never wraps to zero.
- R6: A write (`wr_en` = 1) with `wr_data` bit CLR_BIT (default 31) set to 1 makes the count zero after the next clock edge. A write with that bit at 0 has no effect on the count.
- R7: A clear written while the button is still low takes priority over the increment in that cycle. The count reads zero after that edge and then counts 1, 2, … on the following edges.
- R8: `rd_data[CNT_W-1:0]` carries the count, and every bit of `rd_data` above bit CNT_W-1 reads zero (bits [31:29] at the default width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one count per period |
| rst_n | input | 1 | Block reset, asynchronous assert, active low |
| btn_n | input | 1 | Asynchronous reset-button level, low = pressed |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | REG_W (32) | Write data; bit CLR_BIT requests a clear |
| rd_data | output | REG_W (32) | Current count, zero-extended |

## Verification
A level change on `btn_n` reaches the count at the third rising edge after the change: two synchronizer flops plus the counter register. A clear strobe takes effect at the first edge after it, and `rd_data` follows the count with no further register. The bench drives inputs on the falling edge and steps a behavioural model on every rising edge. The model uses a two-entry queue to delay the button level and applies clear before increment. The bench compares `rd_data` a quarter period after each rising edge, so each due result is sampled in the cycle it becomes visible. The saturation case is run with a narrow counter width so that full scale is reached in a few dozen cycles.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;
  localparam int REG_W_DFLT   = 32;
  localparam int CLR_BIT_DFLT = 31;
  localparam int CNT_W_DFLT   = 29;
  localparam int SYNC_DFLT    = 2;
endpackage

// File: rtl/rsthold_sync.sv
// Multi-flop synchronizer for a slow asynchronous level.
module rsthold_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sq_q;
  logic [STAGES-1:0] sq_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sq_d = din;
    end else begin : g_many
      always_comb sq_d = {sq_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_q <= {STAGES{RST_VAL}};
    else        sq_q <= sq_d;
  end

  assign dout = sq_q[STAGES-1];
endmodule

// File: rtl/rsthold_counter.sv
// Saturating hold counter; clear wins over increment.
module rsthold_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_full;

  always_comb begin
    at_full = (cnt_q == FULL);
    cnt_en  = clr | (run & ~at_full);
    cnt_d   = clr ? '0 : (cnt_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rsthold_regif.sv
// Register view: clear decode on writes, zero-extended read.
module rsthold_regif #(
  parameter int REG_W   = 32,
  parameter int CLR_BIT = 31,
  parameter int CNT_W   = 29
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [CNT_W-1:0] count,
  output logic             clr,
  output logic [REG_W-1:0] rd_data
);
  logic unused_wr_bits;

  assign clr            = wr_en & wr_data[CLR_BIT];
  assign unused_wr_bits = ^wr_data;

  generate
    if (CNT_W < REG_W) begin : g_pad
      assign rd_data = {{(REG_W-CNT_W){1'b0}}, count};
    end else begin : g_full
      assign rd_data = count[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rsthold_meter.sv
module rsthold_meter
  import rsthold_pkg::*;
#(
  parameter int CNT_W       = CNT_W_DFLT,
  parameter int SYNC_STAGES = SYNC_DFLT,
  parameter int REG_W       = REG_W_DFLT,
  parameter int CLR_BIT     = CLR_BIT_DFLT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  logic             btn_sync_n;
  logic             clr;
  logic [CNT_W-1:0] count;

  rsthold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (btn_n),
    .dout (btn_sync_n)
  );

  rsthold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (~btn_sync_n),
    .clr  (clr),
    .count(count)
  );

  rsthold_regif #(.REG_W(REG_W), .CLR_BIT(CLR_BIT), .CNT_W(CNT_W)) u_reg (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .count  (count),
    .clr    (clr),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/rsthold_meter_chk.sv
module rsthold_meter_chk #(
  parameter int CNT_W   = 29,
  parameter int REG_W   = 32,
  parameter int CLR_BIT = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] FULL = (REG_W)'({CNT_W{1'b1}});

  logic clr_req;
  assign clr_req = wr_en & wr_data[CLR_BIT];

  // R6: a clear write empties the count at the next edge
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (rd_data == '0));

  // R2 / R5: without a clear the count only stays or steps by one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> ((rd_data == $past(rd_data)) || (rd_data == $past(rd_data) + 1)));

  // R5: full scale is sticky
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && rd_data == FULL) |=> (rd_data == FULL));

  // R3: released long enough and not cleared means frozen
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && btn_n && $past(btn_n) && $past(btn_n, 2)) |=> $stable(rd_data));

  // R8: no bits above the count width
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data >> CNT_W) == '0));
endmodule

bind rsthold_meter rsthold_meter_chk #(.CNT_W(CNT_W), .REG_W(REG_W), .CLR_BIT(CLR_BIT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .btn_n  (btn_n),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data)
);

// File: tb/test_rsthold_meter.sv
`timescale 1ns/1ps
module test_rsthold_meter;
  localparam int CLK_P = 40;
  localparam int TB_CNT_W = 6;
  localparam int MAXV = (1 << TB_CNT_W) - 1;

  logic        clk;
  logic        rst_n;
  logic        btn_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int    compared = 0;
  int    mismatched = 0;
  string cur_req = "R1";

  int m_cnt;
  bit sq[$];

  rsthold_meter #(.CNT_W(TB_CNT_W)) i_rsthold_meter (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: two-entry delay queue on the button, clear before count
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      sq = '{1'b1, 1'b1};
    end else begin
      if (wr_en && wr_data[31]) m_cnt = 0;
      else if (sq[1] == 1'b0 && m_cnt < MAXV) m_cnt = m_cnt + 1;
      sq.push_front(btn_n);
      void'(sq.pop_back());
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // compare a quarter period after every rising edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      check(cur_req, int'(rd_data[TB_CNT_W-1:0]), m_cnt);
      check("R8", int'(rd_data[31:TB_CNT_W]), 0);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; btn_n = 1'b1; wr_en = 1'b0; wr_data = '0;
    cycles(4);
    rst_n = 1'b1;
    // R1: idle after reset
    cur_req = "R1"; cycles(4);
    check("R1", int'(rd_data), 0);
    // R2: press, count starts on the third edge
    cur_req = "R2"; btn_n = 1'b0; cycles(10);
    check("R2", int'(rd_data), 8);
    // R3: release, two trailing counts then frozen
    cur_req = "R3"; btn_n = 1'b1; cycles(8);
    check("R3", int'(rd_data), 10);
    // R4: second press accumulates
    cur_req = "R4"; btn_n = 1'b0; cycles(5);
    btn_n = 1'b1; cycles(5);
    check("R4", int'(rd_data), 15);
    // R6: write without the clear bit, then with it
    cur_req = "R6"; write(32'h7fff_ffff); cycles(2);
    check("R6", int'(rd_data), 15);
    write(32'h8000_0000); cycles(2);
    check("R6", int'(rd_data), 0);
    // R7: clear while pressed restarts from zero
    cur_req = "R7"; btn_n = 1'b0; cycles(6);
    write(32'h8000_0000); cycles(4);
    check("R7", int'(rd_data), 4);
    btn_n = 1'b1; cycles(5);
    // R5: saturation at full scale
    cur_req = "R5"; write(32'h8000_0000);
    btn_n = 1'b0; cycles(80);
    check("R5", int'(rd_data), MAXV);
    btn_n = 1'b1; cycles(5);
    check("R5", int'(rd_data), MAXV);
    write(32'h8000_0000); cycles(2);
    check("R6", int'(rd_data), 0);
    finish_run();
  end
endmodule